// File: doc/BRIEF.md
# External Master Bus Access Responder

This block answers bus cycles that an outside master runs on a microcontroller's external bus after it has taken ownership of that bus. When external-master operation is enabled and the master owns the bus, a transfer-start strobe opens an access. The presented address is tested against an internal window, which is set by a base value and a mask. A matching access goes to a simple internal memory port. Every matching access then ends with exactly one of three termination pulses: acknowledge, transfer error or retry.

An address that misses the window gets no reply of any kind, so some other agent on the bus can serve it. Errors come from two places: an error flag raised by the internal memory port, or an offset that lies inside the window but beyond the memory depth. A busy flag from the memory port asks the master to retry. A separate classifier decodes the three termination lines that are sampled from an external slave. It reports which outcome they mean, and an asserted error line overrides the other two.

Top module: `extm_responder`

## Requirements
- R1: A start strobe has no effect unless external-master mode is enabled and the master owns the bus in the same cycle: no memory request and no termination follow.
- R2: An address matches when ((addr ^ base) & mask) == 0. A start with a non-matching address gives no memory request and no termination.
- R3: The start of an accepted access captures the write flag, the write data and the offset (addr & ~mask). In the cycle after the start, the memory request is raised with those captured values, unless the offset is out of range.
- R4: A matching access that sees neither busy nor error during its request cycle is acknowledged for exactly one cycle, two cycles after the start was sampled. For a read, rdata carries the word the memory returned in the request cycle. rdata is zero in every cycle that is not a read acknowledge.
- R5: An offset at or above DEPTH, or an error flag from the memory port during the request cycle, gives a one-cycle transfer error instead of acknowledge. An out-of-range offset raises no memory request.
- R6: The busy flag with no error during the request cycle gives a one-cycle retry.
- R7: Each accepted access produces exactly one termination pulse, with precedence error over retry over acknowledge. No termination is raised while idle.
- R8: After reset all outputs are low and the block is idle.
- R9: A start strobe sampled during the request or the termination cycle is ignored. The block is idle in the cycle after a termination and accepts a start sampled in that cycle.
- R10: The classifier registers its inputs each cycle and reports 3 (error) whenever the sampled error line is high. It reports 2 (retry) for retry with error low, 1 (normal) for acknowledge alone, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transfer-start strobe from the external master |
| mode_en_i | input | 1 | External-master operation enabled |
| bus_owned_i | input | 1 | External master currently owns the bus |
| addr_i | input | AW | Address presented with the start strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | DW | Write data presented with the start strobe |
| cfg_base_i | input | AW | Window base address |
| cfg_mask_i | input | AW | Window mask (1 = compared bit) |
| mem_req_o | output | 1 | Internal memory request |
| mem_we_o | output | 1 | Internal memory write enable |
| mem_addr_o | output | IDX_W | Internal memory word index |
| mem_wdata_o | output | DW | Internal memory write data |
| mem_rdata_i | input | DW | Internal memory read data, same cycle as request |
| mem_busy_i | input | 1 | Memory port cannot serve now (retry) |
| mem_err_i | input | 1 | Memory port reports an error |
| ack_o | output | 1 | Normal termination pulse |
| err_o | output | 1 | Transfer error termination pulse |
| retry_o | output | 1 | Retry termination pulse |
| rdata_o | output | DW | Read data, valid with acknowledge |
| snoop_ack_i | input | 1 | Sampled acknowledge from an external slave |
| snoop_err_i | input | 1 | Sampled error from an external slave |
| snoop_retry_i | input | 1 | Sampled retry from an external slave |
| snoop_kind_o | output | 2 | Classified termination, one cycle after sampling |

## Verification
The assertions assume that the window base and mask stay constant while an access is in flight. They also read the busy and error flags only in the cycle that the memory request is raised. The range assertion further assumes that the mask covers every address bit above the memory index, so that any offset fits the index width. The stimulus keeps one base and mask for the whole run, with a 64-word window over a 48-word memory. It drives busy and error steadily across each access and changes the address right after the start, so that the bench sees whether the start value was captured.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

   typedef enum logic [1:0] {
      TK_NONE   = 2'd0,
      TK_NORMAL = 2'd1,
      TK_RETRY  = 2'd2,
      TK_ERROR  = 2'd3
   } term_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_RESP   = 2'd2
   } ctrl_state_e;

   function automatic term_kind_e classify_term(input logic ack, input logic err, input logic rty);
      term_kind_e k;
      if (err)
         k = TK_ERROR;
      else if (rty)
         k = TK_RETRY;
      else if (ack)
         k = TK_NORMAL;
      else
         k = TK_NONE;
      return k;
   endfunction

   function automatic term_kind_e pick_outcome(input logic fault, input logic busy);
      term_kind_e k;
      if (fault)
         k = TK_ERROR;
      else if (busy)
         k = TK_RETRY;
      else
         k = TK_NORMAL;
      return k;
   endfunction

endpackage

// File: rtl/xbr_window_match.sv
module xbr_window_match #(
   parameter int AW    = 16,
   parameter int DEPTH = 48,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [AW-1:0]    addr_i,
   input  logic [AW-1:0]    base_i,
   input  logic [AW-1:0]    mask_i,
   output logic             hit_o,
   output logic             in_range_o,
   output logic [IDX_W-1:0] index_o
);

   localparam logic [AW-1:0] DEPTH_V = AW'(DEPTH);

   logic [AW-1:0] offset;

   always_comb begin
      offset     = addr_i & ~mask_i;
      hit_o      = ((addr_i ^ base_i) & mask_i) == '0;
      in_range_o = offset < DEPTH_V;
      index_o    = offset[IDX_W-1:0];
   end

endmodule

// File: rtl/xbr_term_classify.sv
module xbr_term_classify
   import xbr_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ack_i,
   input  logic       err_i,
   input  logic       rty_i,
   output logic [1:0] kind_o
);

   term_kind_e kind_now;

   always_comb kind_now = classify_term(ack_i, err_i, rty_i);

   generate
      if (REG_OUT) begin : g_reg
         term_kind_e kind_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               kind_q <= TK_NONE;
            else
               kind_q <= kind_now;
         end
         assign kind_o = kind_q;
      end else begin : g_comb
         assign kind_o = kind_now;
      end
   endgenerate

endmodule

// File: rtl/xbr_ctrl.sv
module xbr_ctrl
   import xbr_pkg::*;
#(
   parameter int DW        = 16,
   parameter int IDX_W     = 6,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic             in_range_i,
   input  logic [IDX_W-1:0] index_i,
   input  logic             wr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [DW-1:0]    mem_rdata_i,
   input  logic             mem_busy_i,
   input  logic             mem_err_i,
   output logic             mem_req_o,
   output logic             mem_we_o,
   output logic [IDX_W-1:0] mem_addr_o,
   output logic [DW-1:0]    mem_wdata_o,
   output logic             ack_o,
   output logic             err_o,
   output logic             retry_o,
   output logic [DW-1:0]    rdata_o,
   output logic             idle_o
);

   ctrl_state_e      state_q;
   logic [IDX_W-1:0] idx_q;
   logic             we_q;
   logic [DW-1:0]    wdata_q;
   logic             rng_err_q;
   term_kind_e       outcome_q;
   logic [DW-1:0]    rdata_q;
   term_kind_e       outcome_d;

   always_comb outcome_d = pick_outcome(rng_err_q | mem_err_i, mem_busy_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         idx_q     <= '0;
         we_q      <= 1'b0;
         wdata_q   <= '0;
         rng_err_q <= 1'b0;
         outcome_q <= TK_NONE;
         rdata_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept_i) begin
                  idx_q     <= index_i;
                  we_q      <= wr_i;
                  wdata_q   <= wdata_i;
                  rng_err_q <= ~in_range_i;
                  state_q   <= ST_ACCESS;
               end
            end
            ST_ACCESS: begin
               outcome_q <= outcome_d;
               if (outcome_d == TK_NORMAL && !we_q)
                  rdata_q <= mem_rdata_i;
               state_q <= ST_RESP;
            end
            ST_RESP: begin
               outcome_q <= TK_NONE;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic in_resp;

   always_comb begin
      in_resp     = state_q == ST_RESP;
      idle_o      = state_q == ST_IDLE;
      mem_req_o   = (state_q == ST_ACCESS) && !rng_err_q;
      mem_we_o    = mem_req_o && we_q;
      mem_addr_o  = idx_q;
      mem_wdata_o = wdata_q;
      ack_o       = in_resp && outcome_q == TK_NORMAL;
      err_o       = in_resp && outcome_q == TK_ERROR;
      retry_o     = in_resp && outcome_q == TK_RETRY;
   end

   generate
      if (ZERO_IDLE) begin : g_zero_rdata
         assign rdata_o = (ack_o && !we_q) ? rdata_q : '0;
      end else begin : g_hold_rdata
         assign rdata_o = rdata_q;
      end
   endgenerate

endmodule

// File: rtl/extm_responder.sv
module extm_responder
   import xbr_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int DEPTH     = 48,
   parameter bit ZERO_IDLE = 1'b1,
   parameter bit CLS_REG   = 1'b1,
   localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             mode_en_i,
   input  logic             bus_owned_i,
   input  logic [AW-1:0]    addr_i,
   input  logic             wr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [AW-1:0]    cfg_base_i,
   input  logic [AW-1:0]    cfg_mask_i,
   output logic             mem_req_o,
   output logic             mem_we_o,
   output logic [IDX_W-1:0] mem_addr_o,
   output logic [DW-1:0]    mem_wdata_o,
   input  logic [DW-1:0]    mem_rdata_i,
   input  logic             mem_busy_i,
   input  logic             mem_err_i,
   output logic             ack_o,
   output logic             err_o,
   output logic             retry_o,
   output logic [DW-1:0]    rdata_o,
   input  logic             snoop_ack_i,
   input  logic             snoop_err_i,
   input  logic             snoop_retry_i,
   output logic [1:0]       snoop_kind_o
);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("extm_responder: AW must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("extm_responder: DW must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("extm_responder: DEPTH must be at least 2");
      end
      if (IDX_W >= AW) begin : g_bad_idx
         $error("extm_responder: memory index must be narrower than the address");
      end
   endgenerate

   logic             hit;
   logic             in_range;
   logic [IDX_W-1:0] index;
   logic             accept;
   logic             ctrl_idle;

   xbr_window_match #(
      .AW   (AW),
      .DEPTH(DEPTH)
   ) u_match (
      .addr_i    (addr_i),
      .base_i    (cfg_base_i),
      .mask_i    (cfg_mask_i),
      .hit_o     (hit),
      .in_range_o(in_range),
      .index_o   (index)
   );

   always_comb accept = start_i && mode_en_i && bus_owned_i && hit;

   xbr_ctrl #(
      .DW       (DW),
      .IDX_W    (IDX_W),
      .ZERO_IDLE(ZERO_IDLE)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .in_range_i (in_range),
      .index_i    (index),
      .wr_i       (wr_i),
      .wdata_i    (wdata_i),
      .mem_rdata_i(mem_rdata_i),
      .mem_busy_i (mem_busy_i),
      .mem_err_i  (mem_err_i),
      .mem_req_o  (mem_req_o),
      .mem_we_o   (mem_we_o),
      .mem_addr_o (mem_addr_o),
      .mem_wdata_o(mem_wdata_o),
      .ack_o      (ack_o),
      .err_o      (err_o),
      .retry_o    (retry_o),
      .rdata_o    (rdata_o),
      .idle_o     (ctrl_idle)
   );

   xbr_term_classify #(
      .REG_OUT(CLS_REG)
   ) u_classify (
      .clk   (clk),
      .rst_n (rst_n),
      .ack_i (snoop_ack_i),
      .err_i (snoop_err_i),
      .rty_i (snoop_retry_i),
      .kind_o(snoop_kind_o)
   );

endmodule

// File: rtl/xbr_checker.sv
module xbr_checker #(
   parameter int AW      = 16,
   parameter int DEPTH   = 48,
   parameter bit CLS_REG = 1'b1,
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             mode_en_i,
   input logic             bus_owned_i,
   input logic [AW-1:0]    addr_i,
   input logic [AW-1:0]    cfg_base_i,
   input logic [AW-1:0]    cfg_mask_i,
   input logic             mem_req_o,
   input logic [IDX_W-1:0] mem_addr_o,
   input logic             ack_o,
   input logic             err_o,
   input logic             retry_o,
   input logic             snoop_err_i,
   input logic [1:0]       snoop_kind_o,
   input logic             idle
);

   localparam logic [IDX_W:0] DEPTH_V = DEPTH[IDX_W:0];

   logic any_term;
   assign any_term = ack_o || err_o || retry_o;

   assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start_i && !(mode_en_i && bus_owned_i)) |=> idle);

   assert_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start_i && (((addr_i ^ cfg_base_i) & cfg_mask_i) != '0)) |=> idle);

   assert_req_then_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> any_term);

   assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);

   assert_req_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> ({1'b0, mem_addr_o} < DEPTH_V));

   assert_retry_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      retry_o |=> !retry_o);

   assert_one_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ack_o, err_o, retry_o}));

   assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !any_term);

   assert_back_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any_term |=> idle);

   generate
      if (CLS_REG) begin : g_cls_chk
         assert_err_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            snoop_err_i |=> (snoop_kind_o == 2'd3));
      end
   endgenerate

endmodule

bind extm_responder xbr_checker #(
   .AW     (AW),
   .DEPTH  (DEPTH),
   .CLS_REG(CLS_REG)
) u_xbr_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .mode_en_i   (mode_en_i),
   .bus_owned_i (bus_owned_i),
   .addr_i      (addr_i),
   .cfg_base_i  (cfg_base_i),
   .cfg_mask_i  (cfg_mask_i),
   .mem_req_o   (mem_req_o),
   .mem_addr_o  (mem_addr_o),
   .ack_o       (ack_o),
   .err_o       (err_o),
   .retry_o     (retry_o),
   .snoop_err_i (snoop_err_i),
   .snoop_kind_o(snoop_kind_o),
   .idle        (ctrl_idle)
);

// File: tb/test_extm_responder.sv
module test_extm_responder;

   localparam int AW    = 16;
   localparam int DW    = 16;
   localparam int DEPTH = 48;
   localparam int IDX_W = 6;
   localparam logic [AW-1:0] BASE = 16'h1240;
   localparam logic [AW-1:0] MASK = 16'hFFC0;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic             mode_en_i = 1'b0;
   logic             bus_owned_i = 1'b0;
   logic [AW-1:0]    addr_i = '0;
   logic             wr_i = 1'b0;
   logic [DW-1:0]    wdata_i = '0;
   logic [AW-1:0]    cfg_base_i = BASE;
   logic [AW-1:0]    cfg_mask_i = MASK;
   logic             mem_req_o;
   logic             mem_we_o;
   logic [IDX_W-1:0] mem_addr_o;
   logic [DW-1:0]    mem_wdata_o;
   logic [DW-1:0]    mem_rdata_i;
   logic             mem_busy_i = 1'b0;
   logic             mem_err_i = 1'b0;
   logic             ack_o;
   logic             err_o;
   logic             retry_o;
   logic [DW-1:0]    rdata_o;
   logic             snoop_ack_i = 1'b0;
   logic             snoop_err_i = 1'b0;
   logic             snoop_retry_i = 1'b0;
   logic [1:0]       snoop_kind_o;

   int errors = 0;
   int checks = 0;

   logic [DW-1:0] bmem [DEPTH];
   logic [DW-1:0] emem [64];

   always #10 clk = ~clk;

   extm_responder i_extm_responder (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .mode_en_i    (mode_en_i),
      .bus_owned_i  (bus_owned_i),
      .addr_i       (addr_i),
      .wr_i         (wr_i),
      .wdata_i      (wdata_i),
      .cfg_base_i   (cfg_base_i),
      .cfg_mask_i   (cfg_mask_i),
      .mem_req_o    (mem_req_o),
      .mem_we_o     (mem_we_o),
      .mem_addr_o   (mem_addr_o),
      .mem_wdata_o  (mem_wdata_o),
      .mem_rdata_i  (mem_rdata_i),
      .mem_busy_i   (mem_busy_i),
      .mem_err_i    (mem_err_i),
      .ack_o        (ack_o),
      .err_o        (err_o),
      .retry_o      (retry_o),
      .rdata_o      (rdata_o),
      .snoop_ack_i  (snoop_ack_i),
      .snoop_err_i  (snoop_err_i),
      .snoop_retry_i(snoop_retry_i),
      .snoop_kind_o (snoop_kind_o)
   );

   // memory model behind the internal port
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) bmem[i] <= '0;
      end else if (mem_req_o && mem_we_o && !mem_busy_i && !mem_err_i && mem_addr_o < IDX_W'(DEPTH)) begin
         bmem[mem_addr_o] <= mem_wdata_o;
      end
   end

   assign mem_rdata_i = (mem_addr_o < IDX_W'(DEPTH)) ? bmem[mem_addr_o] : '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_quiet(input string req, input string what);
      chk(!mem_req_o && !ack_o && !err_o && !retry_o && rdata_o == '0, req, what,
          {26'd0, mem_req_o, ack_o, err_o, retry_o, 2'd0}, 32'd0);
   endtask

   // one complete access; expected results derived from the requirements
   task automatic access(input logic [AW-1:0] a, input bit we, input logic [DW-1:0] wd,
                         input bit bz, input bit er, input bit en, input bit own, input string req);
      int  off;
      bit  match;
      bit  rng;
      int  kind;
      off   = int'(a & ~MASK);
      match = en && own && (((a ^ BASE) & MASK) == '0);
      rng   = off >= DEPTH;
      if (!match)         kind = 0;
      else if (rng || er) kind = 3;
      else if (bz)        kind = 2;
      else                kind = 1;

      @(negedge clk);
      start_i = 1'b1; addr_i = a; wr_i = we; wdata_i = wd;
      mode_en_i = en; bus_owned_i = own; mem_busy_i = bz; mem_err_i = er;
      @(negedge clk);
      start_i = 1'b0; addr_i = ~a; wdata_i = ~wd; wr_i = ~we;
      // R3: request cycle
      chk(mem_req_o == (kind != 0 && !rng), req, "mem_req", {31'd0, mem_req_o}, {31'd0, kind != 0 && !rng});
      if (kind != 0 && !rng) begin
         chk(mem_addr_o == off[IDX_W-1:0], "R3", "mem_addr", {26'd0, mem_addr_o}, off);
         chk(mem_we_o == we, "R3", "mem_we", {31'd0, mem_we_o}, {31'd0, we});
         if (we) chk(mem_wdata_o == wd, "R3", "mem_wdata", {16'd0, mem_wdata_o}, {16'd0, wd});
      end
      chk(!ack_o && !err_o && !retry_o, "R7", "early termination",
          {29'd0, ack_o, err_o, retry_o}, 32'd0);
      @(negedge clk);
      // termination cycle
      chk(ack_o == (kind == 1), (kind == 1) ? "R4" : req, "ack", {31'd0, ack_o}, {31'd0, kind == 1});
      chk(err_o == (kind == 3), (kind == 3) ? "R5" : req, "err", {31'd0, err_o}, {31'd0, kind == 3});
      chk(retry_o == (kind == 2), (kind == 2) ? "R6" : req, "retry", {31'd0, retry_o}, {31'd0, kind == 2});
      if (kind == 1 && !we)
         chk(rdata_o == emem[off], "R4", "read data", {16'd0, rdata_o}, {16'd0, emem[off]});
      else
         chk(rdata_o == '0, "R4", "rdata outside read ack", {16'd0, rdata_o}, 32'd0);
      if (kind == 1 && we) emem[off] = wd;
      @(negedge clk);
      chk_quiet("R9", "not idle after termination");
      mem_busy_i = 1'b0; mem_err_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int acks;
      int reqs;
      for (int i = 0; i < 64; i++) emem[i] = '0;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk_quiet("R8", "outputs during reset");
      chk(snoop_kind_o == 2'd0, "R8", "classifier reset", {30'd0, snoop_kind_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_quiet("R8", "outputs after reset");

      // R3 R4 R5: write sweep across the whole window, then read back
      for (int o = 0; o < 64; o++)
         access(BASE | AW'(o), 1'b1, DW'(16'hA50F ^ (o * 16'h0307)), 1'b0, 1'b0, 1'b1, 1'b1, "R5");
      for (int o = 0; o < 64; o++)
         access(BASE | AW'(o), 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b1, "R5");

      // R6: busy gives retry and leaves memory untouched
      for (int o = 0; o < 48; o += 5)
         access(BASE | AW'(o), 1'b1, 16'hDEAD, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
      // R5: memory error
      for (int o = 1; o < 48; o += 7)
         access(BASE | AW'(o), 1'b1, 16'hBEEF, 1'b0, 1'b1, 1'b1, 1'b1, "R5");
      // R7: error beats retry
      for (int o = 2; o < 64; o += 9)
         access(BASE | AW'(o), o[0], 16'h1111, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
      for (int o = 0; o < 48; o += 5)
         access(BASE | AW'(o), 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b1, "R6");

      // R2: any compared bit flipped misses the window
      for (int k = 6; k < AW; k++)
         access(BASE ^ AW'(1 << k), 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
      // R1: mode and ownership gating
      access(BASE | 16'd3, 1'b1, 16'h7777, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
      access(BASE | 16'd3, 1'b1, 16'h7777, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
      access(BASE | 16'd3, 1'b1, 16'h7777, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
      access(BASE | 16'd3, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b1, "R1");

      // R9: start held high; accepted only when idle (every third cycle)
      acks = 0; reqs = 0;
      @(negedge clk);
      start_i = 1'b1; addr_i = BASE | 16'd7; wr_i = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (i == 5) start_i = 1'b0;
         acks += int'(ack_o);
         reqs += int'(mem_req_o);
      end
      chk(acks == 2, "R9", "acks with held start", acks, 2);
      chk(reqs == 2, "R9", "requests with held start", reqs, 2);
      chk_quiet("R9", "idle after held start");

      // R10: classifier sweep of all input patterns
      for (int p = 0; p < 8; p++) begin
         int exp_k;
         @(negedge clk);
         snoop_ack_i = p[0]; snoop_retry_i = p[1]; snoop_err_i = p[2];
         if (p[2])      exp_k = 3;
         else if (p[1]) exp_k = 2;
         else if (p[0]) exp_k = 1;
         else           exp_k = 0;
         @(negedge clk);
         chk(int'(snoop_kind_o) == exp_k, "R10", "classified kind", {30'd0, snoop_kind_o}, exp_k);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule